// File: doc/BRIEF.md
# 64B/66B Transmit Block Encoder

This block turns each 10-gigabit media-independent interface transfer into one 66-bit line block. A transfer is eight byte lanes of data with one control flag per lane. The encoder emits a 2-bit sync header and a 64-bit payload. A transfer made only of data bytes becomes a data block and its bytes pass through unchanged. A transfer holding any control character becomes a control block. The low byte of that block is a type code, and the type code says how the rest of the payload is laid out.

The mapping covers these cases: an all-control transfer of idles and errors, a frame start in lane 0 or lane 4, and a frame end in any of the eight lanes. Any other pattern gives an error control block. Examples are a start in another lane, data after the terminate character, or an unknown control character. No state is kept between blocks. A single output register puts each block one clock after its transfer, and a valid strobe follows the input strobe.

Top module: `tx_block_encoder`

## Requirements
- R1: When all eight control flags (flag i covers lane i, lane i is bits [8i+7:8i]) are clear, the block carries header 2'b10 and a payload equal to the input data, whatever the byte values.
- R2: Any transfer with at least one control flag set carries header 2'b01. The header is never 2'b00 or 2'b11. A control block's type byte (payload [7:0]) is always one of 8'h1E, 8'h78, 8'h33, 8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1 or 8'hFF.
- R3: If every lane is a control idle (8'h07) or a control error (8'hFE), the type is 8'h1E. Lane j is written as a 7-bit code at payload bit 8+7j: 7'h00 for idle and 7'h1E for error. An all-idle transfer therefore gives payload 64'h1E.
- R4: A start character (8'hFB) in flagged lane 0, with lanes 1 to 7 all data, gives type 8'h78. Data lane i stays at payload bits [8i+7:8i].
- R5: Lanes 0 to 3 as idle or error controls, a start in lane 4 and lanes 5 to 7 as data give type 8'h33. The lane codes sit at bit 8+7j, payload [39:36] is zero, and data lanes 5 to 7 stay at bits [8i+7:8i].
- R6: A terminate (8'hFD) in flagged lane k, with all lower lanes data and all higher lanes idle or error controls, gives type 8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1 or 8'hFF for k = 0 to 7. Data lane i<k moves to payload bit 8+8i. Control lane j>k is a code at bit 8+7j. All other bits are zero.
- R7: Any other flagged pattern gives type 8'h1E with all eight lane codes 7'h1E, that is payload 64'h3C78F1E3C78F1E1E.
- R8: Each block appears on the outputs one clock after the transfer that was sampled with in_valid high, and out_valid equals in_valid one clock earlier.
- R9: A cycle sampled with in_valid low leaves out_hdr and out_payload unchanged.
- R10: While rst_n is low at a clock edge, out_valid becomes 0, out_hdr 2'b01 and out_payload 64'h1E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Transfer present this cycle |
| xg_data | input | 64 | Eight byte lanes, lane 0 in bits [7:0] |
| xg_ctrl | input | 8 | Per-lane control flag, bit i for lane i |
| out_valid | output | 1 | Block present on the outputs |
| out_hdr | output | 2 | Sync header of the block |
| out_payload | output | 64 | Block payload, type byte in bits [7:0] for control blocks |

## Verification
Every encoded block is due exactly one clock after the edge that samples its transfer. The bench drives inputs on the falling edge and reads header, payload and strobe on the next falling edge, so exactly one rising edge lies between them. The latency test also reads the outputs in the same half cycle the new transfer is driven, to show the old block is still present there. The hold and reset results are also due one edge after the stimulus, and they are sampled with the same falling-edge spacing.

// File: rtl/txenc_pkg.sv
// txenc_pkg: constants and helper functions shared by the block encoder.
// Assumes eight byte lanes and the 7-bit lane code width of the line format.
package txenc_pkg;
    localparam int LANES   = 8;
    localparam int BYTE_W  = 8;
    localparam int CODE_W  = 7;
    localparam int TYPE_W  = 8;
    localparam int HDR_W   = 2;
    localparam int PAY_W   = LANES * BYTE_W;
    localparam int SOF_MID = LANES / 2;   // second legal start lane

    localparam logic [HDR_W-1:0] HDR_DATA = 2'b10;
    localparam logic [HDR_W-1:0] HDR_CTRL = 2'b01;

    // characters on the parallel side
    localparam logic [BYTE_W-1:0] CH_IDLE  = 8'h07;
    localparam logic [BYTE_W-1:0] CH_START = 8'hFB;
    localparam logic [BYTE_W-1:0] CH_TERM  = 8'hFD;
    localparam logic [BYTE_W-1:0] CH_ERR   = 8'hFE;

    // 7-bit lane codes on the line side
    localparam logic [CODE_W-1:0] LC_IDLE = 7'h00;
    localparam logic [CODE_W-1:0] LC_ERR  = 7'h1E;

    // block type codes
    localparam logic [TYPE_W-1:0] BT_CTRL = 8'h1E;
    localparam logic [TYPE_W-1:0] BT_SOF0 = 8'h78;
    localparam logic [TYPE_W-1:0] BT_SOF4 = 8'h33;

    localparam logic [PAY_W-1:0] IDLE_BLOCK = {{(PAY_W-TYPE_W){1'b0}}, BT_CTRL};

    // type byte for a frame end at lane k
    function automatic logic [TYPE_W-1:0] term_type(input int k);
        case (k)
            0:       return 8'h87;
            1:       return 8'h99;
            2:       return 8'hAA;
            3:       return 8'hB4;
            4:       return 8'hCC;
            5:       return 8'hD2;
            6:       return 8'hE1;
            default: return 8'hFF;
        endcase
    endfunction

    // bit position of lane j's 7-bit code inside a control payload
    function automatic int code_pos(input int j);
        return TYPE_W + CODE_W * j;
    endfunction

    // bit position of data lane i packed after the type byte
    function automatic int packed_pos(input int i);
        return TYPE_W + BYTE_W * i;
    endfunction

    // error block: every lane code set to the error code
    function automatic logic [PAY_W-1:0] err_block();
        logic [PAY_W-1:0] p;
        p = '0;
        p[TYPE_W-1:0] = BT_CTRL;
        for (int j = 0; j < LANES; j++) p[code_pos(j) +: CODE_W] = LC_ERR;
        return p;
    endfunction
endpackage

// File: rtl/txenc_lane_sort.sv
// txenc_lane_sort: classifies each byte lane as data or as one of the known
// control characters, and gives the 7-bit code of idle/error lanes.
// Assumes the flag bit i belongs to byte lane i. Purely combinational.
module txenc_lane_sort
    import txenc_pkg::*;
(
    input  logic [PAY_W-1:0]        data_i,
    input  logic [LANES-1:0]        ctrl_i,
    output logic [LANES-1:0]        is_data_o,
    output logic [LANES-1:0]        is_fill_o,
    output logic [LANES-1:0]        is_start_o,
    output logic [LANES-1:0]        is_term_o,
    output logic [LANES*CODE_W-1:0] fill_code_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_b;
        logic              c_idle;
        logic              c_err;
        // pick the byte of this lane
        assign lane_b        = data_i[g*BYTE_W +: BYTE_W];
        assign c_idle        = ctrl_i[g] && (lane_b == CH_IDLE);
        assign c_err         = ctrl_i[g] && (lane_b == CH_ERR);
        assign is_data_o[g]  = !ctrl_i[g];
        assign is_fill_o[g]  = c_idle || c_err;
        assign is_start_o[g] = ctrl_i[g] && (lane_b == CH_START);
        assign is_term_o[g]  = ctrl_i[g] && (lane_b == CH_TERM);
        // lane code used when the lane is filler
        assign fill_code_o[g*CODE_W +: CODE_W] = c_err ? LC_ERR : LC_IDLE;
    end
endmodule

// File: rtl/txenc_block_map.sv
// txenc_block_map: maps classified lanes onto a sync header and payload.
// Assumes lane classes from txenc_lane_sort. Purely combinational, no state.
module txenc_block_map
    import txenc_pkg::*;
(
    input  logic [PAY_W-1:0]        data_i,
    input  logic [LANES-1:0]        is_data_i,
    input  logic [LANES-1:0]        is_fill_i,
    input  logic [LANES-1:0]        is_start_i,
    input  logic [LANES-1:0]        is_term_i,
    input  logic [LANES*CODE_W-1:0] fill_code_i,
    output logic [HDR_W-1:0]        hdr_o,
    output logic [PAY_W-1:0]        pay_o
);
    localparam logic [LANES-1:0] SOF_OK = LANES'((1 << 0) | (1 << SOF_MID));
    localparam logic [LANES-1:0] MID_LO = LANES'((1 << SOF_MID) - 1);
    localparam logic [LANES-1:0] MID_HI = ~LANES'((2 << SOF_MID) - 1);

    logic [LANES-1:0] term_hit;
    logic             stray_start;
    logic             sof_lo;
    logic             sof_mid;

    // a start outside the two legal lanes can never be encoded
    assign stray_start = |(is_start_i & ~SOF_OK);
    assign sof_lo  = !stray_start && is_start_i[0] && (&is_data_i[LANES-1:1]);
    assign sof_mid = !stray_start && is_start_i[SOF_MID]
                     && ((is_fill_i & MID_LO) == MID_LO)
                     && ((is_data_i & MID_HI) == MID_HI);

    // frame-end legality for each lane position
    for (genvar k = 0; k < LANES; k++) begin : g_term
        localparam logic [LANES-1:0] LO = LANES'((1 << k) - 1);
        localparam logic [LANES-1:0] HI = ~LANES'((2 << k) - 1);
        assign term_hit[k] = is_term_i[k]
                             && ((is_data_i & LO) == LO)
                             && ((is_fill_i & HI) == HI);
    end

    // choose the block layout; falls back to the error block
    always_comb begin
        hdr_o = HDR_CTRL;
        pay_o = err_block();
        if (&is_data_i) begin
            hdr_o = HDR_DATA;
            pay_o = data_i;
        end else if (&is_fill_i) begin
            pay_o = '0;
            pay_o[TYPE_W-1:0] = BT_CTRL;
            for (int j = 0; j < LANES; j++)
                pay_o[code_pos(j) +: CODE_W] = fill_code_i[j*CODE_W +: CODE_W];
        end else if (sof_lo) begin
            pay_o = data_i;
            pay_o[TYPE_W-1:0] = BT_SOF0;
        end else if (sof_mid) begin
            pay_o = '0;
            pay_o[TYPE_W-1:0] = BT_SOF4;
            for (int j = 0; j < SOF_MID; j++)
                pay_o[code_pos(j) +: CODE_W] = fill_code_i[j*CODE_W +: CODE_W];
            for (int i = SOF_MID + 1; i < LANES; i++)
                pay_o[i*BYTE_W +: BYTE_W] = data_i[i*BYTE_W +: BYTE_W];
        end else if (|term_hit) begin
            pay_o = '0;
            for (int k = 0; k < LANES; k++) begin
                if (term_hit[k]) begin
                    pay_o[TYPE_W-1:0] = term_type(k);
                    for (int i = 0; i < LANES; i++) begin
                        if (i < k)
                            pay_o[packed_pos(i) +: BYTE_W] = data_i[i*BYTE_W +: BYTE_W];
                        else if (i > k)
                            pay_o[code_pos(i) +: CODE_W] = fill_code_i[i*CODE_W +: CODE_W];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/txenc_out_reg.sv
// txenc_out_reg: single output register stage with valid strobe.
// Loads a new block only when the input strobe is high, otherwise holds.
module txenc_out_reg
    import txenc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [HDR_W-1:0] hdr_i,
    input  logic [PAY_W-1:0] pay_i,
    output logic             vld_o,
    output logic [HDR_W-1:0] hdr_o,
    output logic [PAY_W-1:0] pay_o
);
    // register the block; reset shows an idle control block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            hdr_o <= HDR_CTRL;
            pay_o <= IDLE_BLOCK;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                hdr_o <= hdr_i;
                pay_o <= pay_i;
            end
        end
    end
endmodule

// File: rtl/tx_block_encoder.sv
// tx_block_encoder: one parallel transfer in, one 66-bit line block out,
// one clock later. Assumes one transfer per clock; keeps no inter-block state.
module tx_block_encoder
    import txenc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [63:0]      xg_data,
    input  logic [7:0]       xg_ctrl,
    output logic             out_valid,
    output logic [1:0]       out_hdr,
    output logic [63:0]      out_payload
);
    logic [LANES-1:0]        is_data;
    logic [LANES-1:0]        is_fill;
    logic [LANES-1:0]        is_start;
    logic [LANES-1:0]        is_term;
    logic [LANES*CODE_W-1:0] fill_code;
    logic [HDR_W-1:0]        blk_hdr;
    logic [PAY_W-1:0]        blk_pay;

    txenc_lane_sort u_sort (
        .data_i      (xg_data),
        .ctrl_i      (xg_ctrl),
        .is_data_o   (is_data),
        .is_fill_o   (is_fill),
        .is_start_o  (is_start),
        .is_term_o   (is_term),
        .fill_code_o (fill_code)
    );

    txenc_block_map u_map (
        .data_i      (xg_data),
        .is_data_i   (is_data),
        .is_fill_i   (is_fill),
        .is_start_i  (is_start),
        .is_term_i   (is_term),
        .fill_code_i (fill_code),
        .hdr_o       (blk_hdr),
        .pay_o       (blk_pay)
    );

    txenc_out_reg u_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (in_valid),
        .hdr_i (blk_hdr),
        .pay_i (blk_pay),
        .vld_o (out_valid),
        .hdr_o (out_hdr),
        .pay_o (out_payload)
    );
endmodule

// File: rtl/txenc_checks.sv
// txenc_checks: port-level properties of tx_block_encoder, bound to the top.
module txenc_checks
    import txenc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] xg_data,
    input logic [7:0]  xg_ctrl,
    input logic        out_valid,
    input logic [1:0]  out_hdr,
    input logic [63:0] out_payload
);
    logic armed;
    logic type_ok;

    // armed once a full cycle out of reset has passed
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // type byte belongs to the encodable set
    always_comb begin
        case (out_payload[7:0])
            8'h1E, 8'h78, 8'h33, 8'h87, 8'h99, 8'hAA,
            8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF: type_ok = 1'b1;
            default:                          type_ok = 1'b0;
        endcase
    end

    p_hdr_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hdr == HDR_DATA) || (out_hdr == HDR_CTRL));

    p_type_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hdr == HDR_CTRL) |-> type_ok);

    p_ctrl_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid) && ($past(xg_ctrl) != 8'h00)) |-> (out_hdr == HDR_CTRL));

    p_data_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid) && ($past(xg_ctrl) == 8'h00))
        |-> ((out_hdr == HDR_DATA) && (out_payload == $past(xg_data))));

    p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_valid == $past(in_valid)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(in_valid)) |-> ($stable(out_hdr) && $stable(out_payload)));
endmodule

bind tx_block_encoder txenc_checks u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .xg_data     (xg_data),
    .xg_ctrl     (xg_ctrl),
    .out_valid   (out_valid),
    .out_hdr     (out_hdr),
    .out_payload (out_payload)
);

// File: tb/tx_block_encoder_test.sv
`timescale 1ns/1ps
module tx_block_encoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] xg_data = '0;
    logic [7:0]  xg_ctrl = '0;
    logic        out_valid;
    logic [1:0]  out_hdr;
    logic [63:0] out_payload;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [63:0] ERRB = 64'h3C78F1E3C78F1E1E;
    localparam int NV = 16;
    // {req, ctrl, data, expected hdr, expected payload}
    localparam logic [145:0] VEC [NV] = '{
        {8'd1, 8'h00, 64'h0807060504030201, 2'b10, 64'h0807060504030201}, // R1 plain data
        {8'd1, 8'h00, 64'hFDFBFE0707FEFBFD, 2'b10, 64'hFDFBFE0707FEFBFD}, // R1 control-looking data
        {8'd3, 8'hFF, 64'h0707070707070707, 2'b01, 64'h000000000000001E}, // R3 all idle
        {8'd3, 8'hFF, 64'h07070707070707FE, 2'b01, 64'h0000000000001E1E}, // R3 error in lane 0
        {8'd4, 8'h01, 64'hA7A6A5A4A3A2A1FB, 2'b01, 64'hA7A6A5A4A3A2A178}, // R4
        {8'd5, 8'h1F, 64'hC7C6C5FB07070707, 2'b01, 64'hC7C6C50000000033}, // R5 idles
        {8'd5, 8'h1F, 64'h030201FB070707FE, 2'b01, 64'h0302010000001E33}, // R5 error lane 0
        {8'd6, 8'hFF, 64'h07070707070707FD, 2'b01, 64'h0000000000000087}, // R6 k=0
        {8'd6, 8'hFE, 64'hFEFEFEFEFEFEFD5A, 2'b01, 64'h3C78F1E3C7805A99}, // R6 k=1 error fill
        {8'd6, 8'hF8, 64'h07070707FD332211, 2'b01, 64'h00000000332211B4}, // R6 k=3
        {8'd6, 8'hF0, 64'h070707FDDEADBEEF, 2'b01, 64'h000000DEADBEEFCC}, // R6 k=4
        {8'd6, 8'hE0, 64'h0707FD0504030201, 2'b01, 64'h00000504030201D2}, // R6 k=5
        {8'd6, 8'h80, 64'hFD77665544332211, 2'b01, 64'h77665544332211FF}, // R6 k=7
        {8'd7, 8'h04, 64'h0000000000FB0000, 2'b01, ERRB},                 // R7 start lane 2
        {8'd7, 8'h40, 64'h11FD000000000000, 2'b01, ERRB},                 // R7 data after end
        {8'd7, 8'hFF, 64'h070707079C070707, 2'b01, ERRB}                  // R7 unknown char
    };

    tx_block_encoder uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .xg_data     (xg_data),
        .xg_ctrl     (xg_ctrl),
        .out_valid   (out_valid),
        .out_hdr     (out_hdr),
        .out_payload (out_payload)
    );

    always #2 clk = ~clk; // 250 MHz

    task automatic check(input bit ok, input int req, input string what,
                         input logic [65:0] act, input logic [65:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put(input bit v, input logic [7:0] c, input logic [63:0] d);
        in_valid = v;
        xg_ctrl  = c;
        xg_data  = d;
    endtask

    initial begin
        logic [1:0]  hold_h;
        logic [63:0] hold_p;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(out_valid == 1'b0 && out_hdr == 2'b01 && out_payload == 64'h1E, 10,
              "reset", {out_hdr, out_payload}, {2'b01, 64'h1E});
        rst_n = 1'b1;

        // table walk, back to back; R2 header checked in every row
        for (int n = 0; n < NV; n++) begin
            put(1'b1, VEC[n][137:130], VEC[n][129:66]);
            @(negedge clk);
            check(out_valid && out_hdr == VEC[n][65:64] && out_payload == VEC[n][63:0],
                  int'(VEC[n][145:138]), "table", {out_hdr, out_payload}, VEC[n][65:0]);
        end

        // R8 latency: new input driven, old block still present in this half cycle
        put(1'b1, 8'h00, 64'h1122334455667788);
        check(out_hdr == 2'b01 && out_payload == ERRB, 8, "before edge",
              {out_hdr, out_payload}, {2'b01, ERRB});
        @(negedge clk);
        check(out_valid && out_hdr == 2'b10 && out_payload == 64'h1122334455667788, 8,
              "after edge", {out_hdr, out_payload}, {2'b10, 64'h1122334455667788});

        // R9 hold while in_valid low, with changing inputs
        hold_h = out_hdr;
        hold_p = out_payload;
        for (int n = 0; n < 3; n++) begin
            put(1'b0, 8'h04 << n, 64'hFB00FB00FB00FB00 ^ 64'(n));
            @(negedge clk);
            check(!out_valid && out_hdr == hold_h && out_payload == hold_p, 9, "hold",
                  {out_valid, out_hdr, out_payload}, {1'b0, hold_h, hold_p});
        end

        // R8 strobe returns with the next valid transfer
        put(1'b1, 8'hFF, 64'h0707070707070707);
        @(negedge clk);
        check(out_valid && out_hdr == 2'b01 && out_payload == 64'h1E, 8, "resume",
              {out_hdr, out_payload}, {2'b01, 64'h1E});

        // R10 reset mid-run while a data block is presented
        put(1'b1, 8'h00, 64'hCAFEF00DCAFEF00D);
        rst_n = 1'b0;
        @(negedge clk);
        check(!out_valid && out_hdr == 2'b01 && out_payload == 64'h1E, 10, "mid reset",
              {out_valid, out_hdr, out_payload}, {1'b0, 2'b01, 64'h1E});
        rst_n = 1'b1;
        put(1'b0, 8'h00, 64'h0);
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule